// File: doc/BRIEF.md
# Serial Gain Control Interface

This block is the digital control front end of a programmable-gain line driver. It runs on a fast system clock and takes three slow serial lines: an active-low load strobe, a serial clock and serial data. While the strobe is low, it shifts a gain word in one bit per serial clock rising edge, most significant bit first. When the strobe returns high, it commits the assembled word to the active gain register. Until that moment the previously active gain stays in force.

The committed code is limited to the window 1 to 60 and is reported both as a raw code and as a signed gain in dB, where gain equals code minus 29. A code outside the window is clamped to the nearest edge and flagged. A load window that did not carry exactly eight bits is flagged as short, but its register contents are still applied.

Two asynchronous inputs select the power mode. A low wake input forces full power-down and takes priority. Otherwise the transmit-on input chooses between the active amplifier and a low-current between-burst state. The serial lines pass through two-flop synchronizers, so the system clock must run at least four times faster than the serial clock.

Top module: `gain_serial_ctrl`

## Requirements
- R1: After reset, the active code is 1, the dB output is -28, and both the range-error flag and the short-frame flag are 0.
- R2: On each rising edge of the serial clock while the load strobe is low, one data bit is shifted into the shift register, MSB first. When the strobe rises, the shift register contents become the active code.
- R3: While the load strobe is low, the active code and the dB output keep their previous values.
- R4: Serial clock edges that occur while the load strobe is high leave the shift register unchanged. A following frame with zero bits therefore commits the earlier contents.
- R5: The dB output, read as two's complement, equals the active code minus 29.
- R6: A committed value of 0 becomes code 1, and a committed value above 60 becomes code 60. Either case sets the range-error flag. The flag stays set until a commit of a value within 1 to 60 clears it.
- R7: The short-frame flag is set by a commit whose load window carried a bit count other than 8, whether fewer or more. It is cleared by a commit of exactly 8 bits. With more than 8 bits, the last 8 bits are the ones kept.
- R8: While the wake input is low, power-down is 1 and both amplifier-enable and low-current are 0, whatever the transmit-on input is.
- R9: While the wake input is high, transmit-on high gives amplifier-enable 1, and transmit-on low gives low-current 1. Exactly one of the three mode outputs is high at any time.
- R10: A new code becomes visible no later than 4 system clock cycles after the load strobe rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_ni | input | 1 | Load strobe, low opens a load window, rising edge commits |
| sclk_i | input | 1 | Serial clock |
| sdata_i | input | 1 | Serial data, MSB first |
| wake_i | input | 1 | Low forces full power-down |
| tx_on_i | input | 1 | High selects the active amplifier, low selects between-burst |
| amp_en_o | output | 1 | Amplifier active |
| low_cur_o | output | 1 | Between-burst reduced-current state |
| pwr_down_o | output | 1 | Full power-down, output high impedance |
| gain_code_o | output | 8 | Active gain code |
| gain_db_o | output | 8 | Active gain in dB, two's complement |
| range_err_o | output | 1 | Last commit was clamped |
| short_frame_o | output | 1 | Last commit carried a bit count other than 8 |

## Verification
The assertions check several properties on every cycle:
- the power-mode outputs are one-hot, and the wake input overrides transmit-on;
- the active code never leaves the 1 to 60 window, and the dB output always matches the code;
- the code stays frozen while the synchronized strobe is low;
- a raised range-error flag means the code sits on a window edge.

Some behaviours only the bench scenarios can show:
- MSB-first bit ordering, and the retention of the last eight bits after an over-long window;
- the effect of short and empty frames;
- serial clock edges ignored outside a load window;
- the commit latency.

// File: rtl/gsc_pkg.sv
package gsc_pkg;
  typedef enum logic [1:0] {
    PM_OFF    = 2'd0,
    PM_IDLE   = 2'd1,
    PM_ACTIVE = 2'd2
  } pwr_mode_e;

  localparam int unsigned CODE_MIN  = 1;
  localparam int unsigned CODE_MAX  = 60;
  localparam int          DB_OFFSET = 29;
endpackage

// File: rtl/gsc_sync.sv
module gsc_sync #(
  parameter int unsigned W = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic meta_q, sync_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        meta_q <= RST_VAL[g];
        sync_q <= RST_VAL[g];
      end else begin
        meta_q <= d_i[g];
        sync_q <= meta_q;
      end
    end
    assign q_o[g] = sync_q;
  end
endmodule

// File: rtl/gsc_shift.sv
module gsc_shift #(
  parameter int unsigned W     = 8,
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_n_i,
  input  logic             sclk_i,
  input  logic             sdata_i,
  output logic [W-1:0]     word_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             commit_o
);
  localparam logic [CNT_W-1:0] CNT_SAT = '1;

  logic load_q, sclk_q;
  logic open_fall, sclk_rise, take_bit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      load_q <= 1'b1;
      sclk_q <= 1'b0;
    end else begin
      load_q <= load_n_i;
      sclk_q <= sclk_i;
    end
  end

  assign open_fall = load_q & ~load_n_i;
  assign commit_o  = ~load_q & load_n_i;
  assign sclk_rise = sclk_i & ~sclk_q;
  assign take_bit  = ~load_n_i & sclk_rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_o <= '0;
    end else if (take_bit) begin
      word_o <= {word_o[W-2:0], sdata_i};
    end
  end

  // count saturates so over-long windows stay distinguishable from 8
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o <= '0;
    end else if (open_fall) begin
      cnt_o <= take_bit ? CNT_W'(1) : '0;
    end else if (take_bit && cnt_o != CNT_SAT) begin
      cnt_o <= cnt_o + 1'b1;
    end
  end
endmodule

// File: rtl/gsc_commit.sv
module gsc_commit
  import gsc_pkg::*;
#(
  parameter int unsigned W     = 8,
  parameter int unsigned CNT_W = 5
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                commit_i,
  input  logic [W-1:0]        word_i,
  input  logic [CNT_W-1:0]    cnt_i,
  output logic [W-1:0]        code_o,
  output logic signed [W-1:0] db_o,
  output logic                range_err_o,
  output logic                short_o
);
  localparam logic [W-1:0]     LO     = W'(CODE_MIN);
  localparam logic [W-1:0]     HI     = W'(CODE_MAX);
  localparam logic [W-1:0]     OFS    = W'(DB_OFFSET);
  localparam logic [CNT_W-1:0] FULL   = CNT_W'(W);
  localparam logic [W-1:0]     RST_DB = LO - OFS;

  logic [W-1:0] clamped;
  logic         out_of_win;

  always_comb begin
    clamped    = word_i;
    out_of_win = 1'b0;
    if (word_i < LO) begin
      clamped    = LO;
      out_of_win = 1'b1;
    end else if (word_i > HI) begin
      clamped    = HI;
      out_of_win = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_o      <= LO;
      db_o        <= RST_DB;
      range_err_o <= 1'b0;
      short_o     <= 1'b0;
    end else if (commit_i) begin
      code_o      <= clamped;
      db_o        <= clamped - OFS;
      range_err_o <= out_of_win;
      short_o     <= (cnt_i != FULL);
    end
  end
endmodule

// File: rtl/gsc_pwr.sv
module gsc_pwr
  import gsc_pkg::*;
(
  input  logic wake_i,
  input  logic tx_on_i,
  output logic amp_en_o,
  output logic low_cur_o,
  output logic pwr_down_o
);
  pwr_mode_e mode;

  // sleep outranks transmit-on; purely combinational (asynchronous inputs)
  always_comb begin
    if (!wake_i)      mode = PM_OFF;
    else if (tx_on_i) mode = PM_ACTIVE;
    else              mode = PM_IDLE;
  end

  assign amp_en_o   = (mode == PM_ACTIVE);
  assign low_cur_o  = (mode == PM_IDLE);
  assign pwr_down_o = (mode == PM_OFF);
endmodule

// File: rtl/gain_serial_ctrl.sv
module gain_serial_ctrl #(
  parameter int unsigned GAIN_W = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     load_ni,
  input  logic                     sclk_i,
  input  logic                     sdata_i,
  input  logic                     wake_i,
  input  logic                     tx_on_i,
  output logic                     amp_en_o,
  output logic                     low_cur_o,
  output logic                     pwr_down_o,
  output logic [GAIN_W-1:0]        gain_code_o,
  output logic signed [GAIN_W-1:0] gain_db_o,
  output logic                     range_err_o,
  output logic                     short_frame_o
);
  localparam int unsigned CNT_W = $clog2(GAIN_W) + 2;

  logic [2:0]        ser_s;
  logic              load_n_s;
  logic [GAIN_W-1:0] shift_word;
  logic [CNT_W-1:0]  bit_cnt;
  logic              commit;

  gsc_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({load_ni, sclk_i, sdata_i}),
    .q_o   (ser_s)
  );

  assign load_n_s = ser_s[2];

  gsc_shift #(.W(GAIN_W), .CNT_W(CNT_W)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_n_i(load_n_s),
    .sclk_i  (ser_s[1]),
    .sdata_i (ser_s[0]),
    .word_o  (shift_word),
    .cnt_o   (bit_cnt),
    .commit_o(commit)
  );

  gsc_commit #(.W(GAIN_W), .CNT_W(CNT_W)) u_commit (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .commit_i   (commit),
    .word_i     (shift_word),
    .cnt_i      (bit_cnt),
    .code_o     (gain_code_o),
    .db_o       (gain_db_o),
    .range_err_o(range_err_o),
    .short_o    (short_frame_o)
  );

  gsc_pwr u_pwr (
    .wake_i    (wake_i),
    .tx_on_i   (tx_on_i),
    .amp_en_o  (amp_en_o),
    .low_cur_o (low_cur_o),
    .pwr_down_o(pwr_down_o)
  );
endmodule

// File: rtl/gsc_checker.sv
module gsc_checker
  import gsc_pkg::*;
#(
  parameter int unsigned GAIN_W = 8
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     load_n_s,
  input logic                     wake_i,
  input logic                     amp_en_o,
  input logic                     low_cur_o,
  input logic                     pwr_down_o,
  input logic [GAIN_W-1:0]        gain_code_o,
  input logic signed [GAIN_W-1:0] gain_db_o,
  input logic                     range_err_o
);
  AST_MODE_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot({amp_en_o, low_cur_o, pwr_down_o})); // R9

  AST_SLEEP_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wake_i |-> (pwr_down_o && !amp_en_o && !low_cur_o)); // R8

  AST_CODE_IN_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gain_code_o >= GAIN_W'(CODE_MIN)) && (gain_code_o <= GAIN_W'(CODE_MAX))); // R6

  AST_ERR_AT_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    range_err_o |-> (gain_code_o == GAIN_W'(CODE_MIN) || gain_code_o == GAIN_W'(CODE_MAX))); // R6

  AST_DB_TRACKS_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(gain_db_o) == int'(gain_code_o) - DB_OFFSET); // R5

  AST_HOLD_IN_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_n_s |=> $stable(gain_code_o)); // R3
endmodule

bind gain_serial_ctrl gsc_checker #(.GAIN_W(GAIN_W)) u_gsc_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .load_n_s   (load_n_s),
  .wake_i     (wake_i),
  .amp_en_o   (amp_en_o),
  .low_cur_o  (low_cur_o),
  .pwr_down_o (pwr_down_o),
  .gain_code_o(gain_code_o),
  .gain_db_o  (gain_db_o),
  .range_err_o(range_err_o)
);

// File: tb/gain_serial_ctrl_bench.sv
module gain_serial_ctrl_bench;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic load_ni = 1'b1, sclk = 1'b0, sdata = 1'b0;
  logic wake = 1'b1, tx_on = 1'b0;
  logic amp_en, low_cur, pwr_down, range_err, short_frame;
  logic [7:0] code;
  logic signed [7:0] db;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  gain_serial_ctrl u_gain_serial_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .load_ni(load_ni), .sclk_i(sclk),
    .sdata_i(sdata), .wake_i(wake), .tx_on_i(tx_on),
    .amp_en_o(amp_en), .low_cur_o(low_cur), .pwr_down_o(pwr_down),
    .gain_code_o(code), .gain_db_o(db), .range_err_o(range_err),
    .short_frame_o(short_frame)
  );

  // {bits, data, exp_code, exp_err, exp_short}
  localparam logic [29:0] VEC [14] = '{
    {4'd8,  16'h0014, 8'd20, 1'b0, 1'b0},
    {4'd8,  16'h003C, 8'd60, 1'b0, 1'b0},
    {4'd8,  16'h0001, 8'd1,  1'b0, 1'b0},
    {4'd8,  16'h0000, 8'd1,  1'b1, 1'b0},
    {4'd8,  16'h003D, 8'd60, 1'b1, 1'b0},
    {4'd8,  16'h001D, 8'd29, 1'b0, 1'b0},
    {4'd8,  16'h00FF, 8'd60, 1'b1, 1'b0},
    {4'd8,  16'h002A, 8'd42, 1'b0, 1'b0},
    {4'd4,  16'h0005, 8'd60, 1'b1, 1'b1},
    {4'd8,  16'h0007, 8'd7,  1'b0, 1'b0},
    {4'd10, 16'h0305, 8'd5,  1'b0, 1'b1},
    {4'd0,  16'h0000, 8'd5,  1'b0, 1'b1},
    {4'd3,  16'h0003, 8'd43, 1'b0, 1'b1},
    {4'd8,  16'h0032, 8'd50, 1'b0, 1'b0}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_frame(input int nbits, input logic [15:0] data);
    int prev;
    prev = int'(code);
    load_ni = 1'b0;
    wait_clk(4);
    for (int i = nbits - 1; i >= 0; i--) begin
      sdata = data[i];
      wait_clk(4);
      sclk = 1'b1;
      wait_clk(4);
      sclk = 1'b0;
    end
    wait_clk(4);
    chk("R3 hold while strobe low", int'(code), prev);
    load_ni = 1'b1;
    wait_clk(4); // R10: commit latency bound
  endtask

  initial begin
    wait_clk(3);
    // R1 reset state
    chk("R1 code", int'(code), 1);
    chk("R1 db", int'(db), -28);
    chk("R1 err", int'(range_err), 0);
    chk("R1 short", int'(short_frame), 0);
    rst_ni = 1'b1;
    wait_clk(3);

    for (int v = 0; v < 14; v++) begin
      send_frame(int'(VEC[v][29:26]), VEC[v][25:10]);
      chk("R2/R10 code", int'(code), int'(VEC[v][9:2]));
      chk("R5 db", int'(db), int'(VEC[v][9:2]) - 29);
      chk("R6 range err", int'(range_err), int'(VEC[v][1]));
      chk("R7 short frame", int'(short_frame), int'(VEC[v][0]));
    end

    // R4: serial clocks with strobe high must not touch the shift register (holds 0x32)
    sdata = 1'b1;
    for (int i = 0; i < 5; i++) begin
      wait_clk(4); sclk = 1'b1; wait_clk(4); sclk = 1'b0;
    end
    chk("R4 code unchanged outside window", int'(code), 50);
    send_frame(0, 16'h0);
    chk("R4 empty frame recommits old word", int'(code), 50);
    chk("R7 empty frame short", int'(short_frame), 1);

    // R8 / R9 power decode
    wake = 1'b0; tx_on = 1'b1; #1;
    chk("R8 pd tx high", int'({amp_en, low_cur, pwr_down}), 1);
    tx_on = 1'b0; #1;
    chk("R8 pd tx low", int'({amp_en, low_cur, pwr_down}), 1);
    wake = 1'b1; #1;
    chk("R9 between-burst", int'({amp_en, low_cur, pwr_down}), 2);
    tx_on = 1'b1; #1;
    chk("R9 active", int'({amp_en, low_cur, pwr_down}), 4);
    chk("R9 gain unaffected", int'(code), 50);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule